// File: doc/BRIEF.md
# Crossed-Line Pixel Hit Decoder

A column of 45 pixels shares two groups of wires instead of one wire per pixel. Nine hit lines each carry the pulses of five pixels, and five select lines each carry the pulses of nine pixels. A pixel that fires drives its own hit line and its own select line together, so each pixel owns exactly one hit/select pair. Time is measured per hit line, which means the column needs nine time digitisers rather than one per pixel. This block runs at the column end. It works out which pixel produced each pulse.

All line levels come from a matrix that has no clock, so the block first passes every line through a multi-flop synchroniser. For each hit line it detects the synchronised rising edge and waits a configurable settle time of 0 to 3 clocks. It then samples the select lines. When exactly one select line is active, the pixel number is the hit-line number times five plus the select-line position. Any other sample is reported as ambiguous. Events wait per hit line and are issued one at a time in ascending hit-line order through a valid/ready output register. Downstream logic attaches each event to the time word of the same hit line.

Top module: `xl_decoder`

## Requirements
- R1: After reset `evt_valid` is low and stays low until a hit-line pulse arrives.
- R2: When exactly one select line is high at the sample point, the event has flag 0, line field L and index L*5+S, where S is the position (0..4) of that select line.
- R3: When no select line or more than one select line is high at the sample point, the event has flag 1, index 63, and the line field still carries the hit-line number.
- R4: The select lines are sampled `settle_sel`+1 clocks after the synchronised rising edge is first seen. With `settle_sel`=0, a select change applied two clocks after the hit line rises is not seen. With `settle_sel` of 1 or more, it is seen.
- R5: When several hit lines rise in the same clock, each produces one event, issued in ascending hit-line order.
- R6: While `evt_valid` is high and `evt_ready` is low, `evt_valid` stays high and `evt_word` does not change.
- R7: A hit line held high for many clocks produces exactly one event per rising edge.
- R8: A rising edge on a hit line whose previous event is still waiting in its line slot (sampled but not yet moved to the output register) is discarded, and no event is produced for it.
- R9: `evt_word` is packed as flag in bit 10, line number in bits 9:6 and pixel index in bits 5:0. The line number is always below 9.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column-end clock |
| rst | input | 1 | Synchronous active-high reset |
| settle_sel | input | 2 | Clocks to wait after an edge before sampling the select lines |
| hit_lines_in | input | 9 | Asynchronous hit (data) line levels from the receivers |
| sel_lines_in | input | 5 | Asynchronous select (address) line levels from the receivers |
| evt_ready | input | 1 | Downstream accepts the current event |
| evt_valid | output | 1 | An event is held in `evt_word` |
| evt_word | output | 11 | Packed event {flag, line, index} |

## Verification
The assertions check on every clock that a stalled event holds, that an ambiguous event always carries index 63, that a clean event's index falls in the five-pixel range of its own line, and that the line field stays in range. The bench's scenarios show the properties that depend on a sequence of stimulus: the timing of the settle window relative to a select change, ascending order after a simultaneous rise, one event per long pulse, and the discard of a pulse on a line whose slot is still occupied. Constrained random pulses with clean, empty and double select patterns are compared against a bench model of the index arithmetic.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int SETTLE_W = 2;
  typedef logic [SETTLE_W-1:0] settle_t;
endpackage

// File: rtl/xl_sync.sv
module xl_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/xl_line_capture.sv
module xl_line_capture
  import xl_pkg::*;
#(
  parameter int N_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic [N_ADDR-1:0] sel_now,
  input  settle_t           settle,
  input  logic              take,
  output logic              pend,
  output logic [N_ADDR-1:0] pend_sel
);
  logic    armed;
  settle_t cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      cnt      <= '0;
      pend     <= 1'b0;
      pend_sel <= '0;
    end else begin
      if (armed) begin
        if (cnt == '0) begin
          armed    <= 1'b0;
          pend     <= 1'b1;
          pend_sel <= sel_now;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (rise && !pend) begin
        armed <= 1'b1;
        cnt   <= settle;
      end
      if (take) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/xl_event_arb.sv
module xl_event_arb #(
  parameter int N_DATA = 9,
  parameter int N_ADDR = 5,
  parameter int LINE_W = 4,
  parameter int IDX_W  = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_DATA-1:0]              pend,
  input  logic [N_DATA-1:0][N_ADDR-1:0]  pend_sel,
  input  logic                           out_ready,
  output logic [N_DATA-1:0]              take,
  output logic                           out_valid,
  output logic [IDX_W+LINE_W:0]          out_word
);
  localparam int ADDR_W = (N_ADDR > 1) ? $clog2(N_ADDR) : 1;
  localparam logic [IDX_W-1:0] AMBIG_IDX = '1;

  logic              found;
  logic [LINE_W-1:0] sel_line;
  logic [N_ADDR-1:0] sel_bits;
  logic [ADDR_W:0]   ones;
  logic [ADDR_W-1:0] pos;
  logic [IDX_W-1:0]  pix;
  logic              ambig;
  logic              load;

  always_comb begin
    found    = 1'b0;
    sel_line = '0;
    sel_bits = '0;
    for (int i = N_DATA - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found    = 1'b1;
        sel_line = LINE_W'(i);
        sel_bits = pend_sel[i];
      end
    end
  end

  always_comb begin
    ones = '0;
    pos  = '0;
    for (int j = 0; j < N_ADDR; j++) begin
      if (sel_bits[j]) begin
        ones = ones + (ADDR_W+1)'(1);
        pos  = ADDR_W'(j);
      end
    end
    ambig = (ones != (ADDR_W+1)'(1));
    pix   = ambig ? AMBIG_IDX
                  : IDX_W'(IDX_W'(sel_line) * IDX_W'(N_ADDR) + IDX_W'(pos));
  end

  assign load = found && (!out_valid || out_ready);

  always_comb begin
    for (int i = 0; i < N_DATA; i++)
      take[i] = load && (sel_line == LINE_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= {ambig, sel_line, pix};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xl_decoder.sv
module xl_decoder
  import xl_pkg::*;
#(
  parameter int N_DATA      = 9,
  parameter int N_ADDR      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int LINE_W     = $clog2(N_DATA),
  localparam int IDX_W      = $clog2(N_DATA * N_ADDR + 1),
  localparam int WORD_W     = 1 + LINE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        settle_sel,
  input  logic [N_DATA-1:0] hit_lines_in,
  input  logic [N_ADDR-1:0] sel_lines_in,
  input  logic              evt_ready,
  output logic              evt_valid,
  output logic [WORD_W-1:0] evt_word
);
  logic [N_DATA-1:0]             hit_s, hit_q, rise;
  logic [N_ADDR-1:0]             sel_s;
  logic [N_DATA-1:0]             pend, take;
  logic [N_DATA-1:0][N_ADDR-1:0] pend_sel;

  xl_sync #(.W(N_DATA), .STAGES(SYNC_STAGES)) u_sync_hit (
    .clk(clk), .rst(rst), .din(hit_lines_in), .dout(hit_s));

  xl_sync #(.W(N_ADDR), .STAGES(SYNC_STAGES)) u_sync_sel (
    .clk(clk), .rst(rst), .din(sel_lines_in), .dout(sel_s));

  always_ff @(posedge clk) begin
    if (rst) hit_q <= '0;
    else     hit_q <= hit_s;
  end

  assign rise = hit_s & ~hit_q;

  generate
    for (genvar k = 0; k < N_DATA; k++) begin : g_line
      xl_line_capture #(.N_ADDR(N_ADDR)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise[k]),
        .sel_now  (sel_s),
        .settle   (settle_t'(settle_sel)),
        .take     (take[k]),
        .pend     (pend[k]),
        .pend_sel (pend_sel[k])
      );
    end
  endgenerate

  xl_event_arb #(.N_DATA(N_DATA), .N_ADDR(N_ADDR), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .pend_sel  (pend_sel),
    .out_ready (evt_ready),
    .take      (take),
    .out_valid (evt_valid),
    .out_word  (evt_word)
  );
endmodule

// File: rtl/xl_decoder_chk.sv
module xl_decoder_chk #(
  parameter int N_DATA = 9,
  parameter int N_ADDR = 5,
  parameter int WORD_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_ready,
  input logic              evt_valid,
  input logic [WORD_W-1:0] evt_word
);
  localparam int LINE_W = $clog2(N_DATA);
  localparam int IDX_W  = WORD_W - 1 - LINE_W;

  logic              flag;
  logic [LINE_W-1:0] line;
  logic [IDX_W-1:0]  idx;
  assign flag = evt_word[WORD_W-1];
  assign line = evt_word[WORD_W-2:IDX_W];
  assign idx  = evt_word[IDX_W-1:0];

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_word));

  p_ambig_index_r3: assert property (@(posedge clk) disable iff (rst)
    evt_valid && flag |-> idx == {IDX_W{1'b1}});

  p_index_in_line_r2: assert property (@(posedge clk) disable iff (rst)
    evt_valid && !flag |-> (int'(idx) >= int'(line) * N_ADDR) &&
                           (int'(idx) <  int'(line) * N_ADDR + N_ADDR));

  p_line_range_r9: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> int'(line) < N_DATA);
endmodule

bind xl_decoder xl_decoder_chk #(.N_DATA(N_DATA), .N_ADDR(N_ADDR), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .evt_ready(evt_ready), .evt_valid(evt_valid), .evt_word(evt_word));

// File: tb/xl_decoder_test.sv
`timescale 1ns/100ps
module xl_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  settle_sel = 2'd0;
  logic [8:0]  hit_r = '0;
  logic [4:0]  sel_r = '0;
  logic        evt_ready = 1'b1;
  logic        evt_valid;
  logic [10:0] evt_word;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  logic [10:0] ev_log [0:511];
  int ev_n = 0;

  always #2.5 clk = ~clk;

  xl_decoder uut (
    .clk(clk), .rst(rst), .settle_sel(settle_sel),
    .hit_lines_in(hit_r), .sel_lines_in(sel_r),
    .evt_ready(evt_ready), .evt_valid(evt_valid), .evt_word(evt_word));

  always @(negedge clk) begin
    #1;
    if (!rst && evt_valid && evt_ready && ev_n < 512) begin
      ev_log[ev_n] = evt_word;
      ev_n++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [10:0] exp_word(int line, logic [4:0] s);
    int n = 0;
    int p = 0;
    for (int j = 0; j < 5; j++) if (s[j]) begin n++; p = j; end
    if (n == 1) return {1'b0, 4'(line), 6'(line * 5 + p)};
    return {1'b1, 4'(line), 6'd63};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ev(int k, logic [10:0] exp, string tag);
    logic [10:0] a;
    a = (ev_n > k) ? ev_log[k] : 11'h7ff;
    check(ev_n > k && a == exp, tag, {21'd0, a}, {21'd0, exp});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int line, logic [4:0] s, int hi);
    @(negedge clk);
    hit_r[line] = 1'b1;
    sel_r = s;
    repeat (hi) @(negedge clk);
    hit_r[line] = 1'b0;
    repeat (6) @(negedge clk);
    sel_r = '0;
  endtask

  initial begin
    int base;
    int r;
    logic [10:0] held;
    r = $urandom(32'h5eed);
    idle(4);
    rst = 1'b0;
    idle(1);
    check(evt_valid == 1'b0, "R1 valid low after reset", evt_valid, 0);
    idle(10);
    check(evt_valid == 1'b0 && ev_n == 0, "R1 no event while idle", ev_n, 0);

    // R2 / R9 directed corners
    base = ev_n;
    pulse(8, 5'b10000, 3); idle(8);
    chk_ev(base, exp_word(8, 5'b10000), "R2 last pixel index 44");
    check(ev_log[base][10] == 1'b0 && ev_log[base][9:6] == 4'd8 && ev_log[base][5:0] == 6'd44,
          "R9 field packing", ev_log[base], 11'h22c);
    pulse(0, 5'b00001, 3); idle(8);
    chk_ev(base + 1, exp_word(0, 5'b00001), "R2 first pixel index 0");

    // R3 ambiguous samples
    pulse(8, 5'b00000, 3); idle(8);
    chk_ev(base + 2, {1'b1, 4'd8, 6'd63}, "R3 no select line");
    pulse(0, 5'b00101, 3); idle(8);
    chk_ev(base + 3, {1'b1, 4'd0, 6'd63}, "R3 two select lines");
    check(ev_n == base + 4, "R2 one event per pulse", ev_n - base, 4);

    // R4 settle window
    for (int s = 0; s < 3; s++) begin
      base = ev_n;
      settle_sel = (s == 2) ? 2'd3 : 2'(s);
      idle(2);
      @(negedge clk);
      hit_r[5] = 1'b1; sel_r = 5'b00001;
      @(negedge clk);
      @(negedge clk);
      sel_r = 5'b01000;
      idle(10);
      hit_r[5] = 1'b0; sel_r = '0;
      idle(8);
      chk_ev(base, (s == 0) ? exp_word(5, 5'b00001) : exp_word(5, 5'b01000), "R4 settle sample point");
    end
    settle_sel = 2'd0;

    // R5 simultaneous rises
    base = ev_n;
    @(negedge clk);
    hit_r = 9'b1_0001_0001; sel_r = 5'b00100;
    idle(4);
    hit_r = '0;
    idle(6);
    sel_r = '0;
    idle(6);
    chk_ev(base,     exp_word(0, 5'b00100), "R5 order first");
    chk_ev(base + 1, exp_word(4, 5'b00100), "R5 order second");
    chk_ev(base + 2, exp_word(8, 5'b00100), "R5 order third");
    check(ev_n == base + 3, "R5 event count", ev_n - base, 3);

    // R7 long level
    base = ev_n;
    pulse(3, 5'b00010, 40); idle(8);
    check(ev_n == base + 1, "R7 one event for long pulse", ev_n - base, 1);
    chk_ev(base, exp_word(3, 5'b00010), "R7 long pulse value");

    // R6 stall hold and R8 discard
    base = ev_n;
    evt_ready = 1'b0;
    pulse(2, 5'b00001, 3); idle(6);
    check(evt_valid == 1'b1, "R6 valid while stalled", evt_valid, 1);
    held = evt_word;
    check(held == exp_word(2, 5'b00001), "R6 stalled word", held, exp_word(2, 5'b00001));
    pulse(2, 5'b00010, 3); idle(4);
    pulse(2, 5'b00100, 3); idle(4);
    check(evt_valid == 1'b1 && evt_word == held, "R6 word stable under stall", evt_word, held);
    evt_ready = 1'b1;
    idle(10);
    chk_ev(base,     exp_word(2, 5'b00001), "R8 first kept");
    chk_ev(base + 1, exp_word(2, 5'b00010), "R8 queued kept");
    check(ev_n == base + 2, "R8 busy-slot pulse discarded", ev_n - base, 2);

    // random pulses against the model (R2, R3)
    for (int it = 0; it < 60; it++) begin
      int line;
      int kind;
      logic [4:0] s;
      line = int'($urandom % 9);
      kind = int'($urandom % 8);
      if (kind < 6)       s = 5'(1 << ($urandom % 5));
      else if (kind == 6) s = '0;
      else                s = 5'b10010;
      settle_sel = 2'($urandom % 4);
      base = ev_n;
      pulse(line, s, 2 + int'($urandom % 4));
      idle(8);
      chk_ev(base, exp_word(line, s), (kind < 6) ? "R2 random clean" : "R3 random ambiguous");
    end

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule